// File: doc/BRIEF.md
# Input Capture Unit with Byte-Wide Register Access

This block records the value of an externally supplied 16-bit free-running counter when a capture event occurs. The event comes from one of two lines: a dedicated capture pin or the output of an analog comparator. A select input chooses the line. Each line passes through a two-flop synchronizer, and a rising-edge detector turns it into a one-cycle strobe. The captured value is driven out continuously, so the counter logic can use it as its TOP limit.

Software reaches the capture register over an 8-bit address/data register bus. A 16-bit value is moved atomically through one temporary high-byte register. A low-byte read parks the high byte in the temporary register, and the high-byte read that follows returns it. A high-byte write only fills the temporary register. The low-byte write that follows commits both bytes in one cycle.

The block also holds the capture event flag and an interrupt mask register. Each mask bit, together with a global enable, gates one of four request flags into an interrupt request line. The sources are capture, compare B, compare A and overflow. The capture flag is local to this block. The other three flags arrive as inputs.

Top module: `icu_top`

## Requirements
- R1: A capture strobe loads `cnt_i` into the capture register. A pin or comparator line that goes high ahead of clock edge k is captured at edge k+2, taking the `cnt_i` value present at that edge. `cap_val_o` always shows the capture register.
- R2: With `src_sel_i`=0 only `cap_pin_i` triggers captures. With `src_sel_i`=1 only `cmp_out_i` triggers captures. Edges on the unselected line change neither the capture register nor the capture flag.
- R3: Only a low-to-high transition of the selected line causes a capture. A line held high produces exactly one capture.
- R4: A read of the low byte (address 0x96) returns bits 7:0 of the capture register and copies bits 15:8 into the temporary register. A read of the high byte (address 0x97) returns the temporary register.
- R5: A write to the high byte (0x97) loads only the temporary register and leaves the capture register unchanged. A write to the low byte (0x96) loads the capture register with {temporary, written byte} in one cycle.
- R6: When a low-byte write and a capture strobe fall in the same cycle, the written value is kept in the capture register.
- R7: The capture flag is bit 5 of the flag register (address 0x36). A capture strobe sets it. Writing a one to bit 5 clears it, and writing a zero leaves it unchanged. A strobe in the same cycle as a clear leaves it set. Flag register bits 2, 1 and 0 read back the compare B, compare A and overflow flag inputs. All other bits read zero.
- R8: The mask register (address 0x6F) stores bits 5 (capture), 2 (compare B), 1 (compare A) and 0 (overflow). Bits 7:6 and 4:3 always read zero.
- R9: `irq_o[3]`, `irq_o[2]`, `irq_o[1]` and `irq_o[0]` serve the capture, compare B, compare A and overflow sources. Each one is high exactly when its flag, its mask bit and `global_ie_i` are all one.
- R10: After reset the capture register, temporary register, mask register and capture flag are all zero. A read of any address not listed above returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Current counter value |
| cap_pin_i | input | 1 | External capture pin (asynchronous) |
| cmp_out_i | input | 1 | Analog comparator output (asynchronous) |
| src_sel_i | input | 1 | Event source: 0 pin, 1 comparator |
| addr_i | input | 8 | Register bus address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, valid in the read cycle |
| global_ie_i | input | 1 | Global interrupt enable |
| cmpa_flag_i | input | 1 | Compare A request flag |
| cmpb_flag_i | input | 1 | Compare B request flag |
| ovf_flag_i | input | 1 | Overflow request flag |
| cap_val_o | output | 16 | Captured value, usable as counter TOP |
| cap_flag_o | output | 1 | Capture event flag |
| irq_o | output | 4 | Gated requests {capture, compare B, compare A, overflow} |

## Verification
The bench builds the block with its default parameters: a 16-bit value, 8-bit bytes, two sync stages and the default addresses. At this small size all 256 mask-register write values can be swept. The interrupt gating is also swept exhaustively, over every combination of the four mask bits, the four flags and the global enable. Captures are run over an arithmetic sequence of counter values. The exact-cycle cases that the narrow bus makes reachable are driven directly: a strobe colliding with a low-byte write, a strobe colliding with a flag clear, a held-high line, and a second capture that lands between the low-byte read and the high-byte read.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CMP = 1'b1
    } icu_src_e;

    localparam int unsigned N_SRC    = 2;
    localparam int unsigned BIT_CAP  = 5;
    localparam int unsigned BIT_CMPB = 2;
    localparam int unsigned BIT_CMPA = 1;
    localparam int unsigned BIT_OVF  = 0;
    localparam logic [7:0]  MSK_IMPL = 8'h27;
endpackage

// File: rtl/icu_sync_edge.sv
module icu_sync_edge #(
    parameter int unsigned NS     = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] raw_i,
    output logic [NS-1:0] rise_o
);
    localparam int unsigned SW = STAGES + 1;

    typedef struct packed {
        logic [NS-1:0][SW-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    for (genvar s = 0; s < NS; s++) begin : g_src
        always_comb begin
            st_d.sh[s] = {st_q.sh[s][SW-2:0], raw_i[s]};
        end
        assign rise_o[s] = st_q.sh[s][STAGES-1] & ~st_q.sh[s][STAGES];

        p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[s] |=> !rise_o[s]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/icu_cap_regs.sv
module icu_cap_regs #(
    parameter int unsigned CW = 16,
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          stb_i,
    input  logic          rd_lo_i,
    input  logic          rd_hi_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [BW-1:0] wdata_i,
    output logic [BW-1:0] rdata_o,
    output logic [CW-1:0] cap_o
);
    typedef struct packed {
        logic [CW-1:0] cap;
        logic [BW-1:0] tmp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // CPU commit outranks a concurrent capture
        if (wr_lo_i)      st_d.cap = {st_q.tmp, wdata_i};
        else if (stb_i)   st_d.cap = cnt_i;
        if (wr_hi_i)      st_d.tmp = wdata_i;
        else if (rd_lo_i) st_d.tmp = st_q.cap[CW-1:BW];

        rdata_o = '0;
        if (rd_lo_i)      rdata_o = st_q.cap[BW-1:0];
        else if (rd_hi_i) rdata_o = st_q.tmp;
    end

    assign cap_o = st_q.cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !wr_lo_i) |=> cap_o == $past(cnt_i));
    p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> cap_o[BW-1:0] == $past(wdata_i));
    p_hi_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_lo_i && !stb_i) |=> $stable(cap_o));
endmodule

// File: rtl/icu_irq.sv
module icu_irq
    import icu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic       wr_flg_i,
    input  logic       wr_msk_i,
    input  logic [7:0] wdata_i,
    input  logic       gie_i,
    input  logic       cmpa_i,
    input  logic       cmpb_i,
    input  logic       ovf_i,
    output logic [7:0] msk_o,
    output logic [7:0] flg_o,
    output logic       cap_flag_o,
    output logic [3:0] irq_o
);
    typedef struct packed {
        logic [7:0] msk;
        logic       capf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_msk_i) st_d.msk = wdata_i & MSK_IMPL;
        if (stb_i)                           st_d.capf = 1'b1;
        else if (wr_flg_i && wdata_i[BIT_CAP]) st_d.capf = 1'b0;

        flg_o = '0;
        flg_o[BIT_CAP]  = st_q.capf;
        flg_o[BIT_CMPB] = cmpb_i;
        flg_o[BIT_CMPA] = cmpa_i;
        flg_o[BIT_OVF]  = ovf_i;

        irq_o = {4{gie_i}} & {st_q.capf & st_q.msk[BIT_CAP],
                              cmpb_i    & st_q.msk[BIT_CMPB],
                              cmpa_i    & st_q.msk[BIT_CMPA],
                              ovf_i     & st_q.msk[BIT_OVF]};
    end

    assign msk_o      = st_q.msk;
    assign cap_flag_o = st_q.capf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> cap_flag_o);
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_i && !(wr_flg_i && wdata_i[BIT_CAP])) |=> $stable(cap_flag_o));
    p_msk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_msk_i |=> $stable(msk_o));
endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int unsigned CW       = 16,
    parameter int unsigned AW       = 8,
    parameter int unsigned STAGES   = 2,
    parameter logic [7:0]  ADDR_LO  = 8'h96,
    parameter logic [7:0]  ADDR_MSK = 8'h6F,
    parameter logic [7:0]  ADDR_FLG = 8'h36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          cap_pin_i,
    input  logic          cmp_out_i,
    input  logic          src_sel_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o,
    input  logic          global_ie_i,
    input  logic          cmpa_flag_i,
    input  logic          cmpb_flag_i,
    input  logic          ovf_flag_i,
    output logic [CW-1:0] cap_val_o,
    output logic          cap_flag_o,
    output logic [3:0]    irq_o
);
    localparam int unsigned BW = 8;
    localparam logic [AW-1:0] A_LO  = AW'(ADDR_LO);
    localparam logic [AW-1:0] A_HI  = AW'(ADDR_LO + 8'd1);
    localparam logic [AW-1:0] A_MSK = AW'(ADDR_MSK);
    localparam logic [AW-1:0] A_FLG = AW'(ADDR_FLG);

    logic [N_SRC-1:0] rise;
    logic             stb;
    logic             hit_lo, hit_hi, hit_msk, hit_flg;
    logic [BW-1:0]    cap_rd, msk, flg;

    icu_sync_edge #(.NS(N_SRC), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({cmp_out_i, cap_pin_i}),
        .rise_o (rise)
    );

    assign stb = (src_sel_i == SRC_CMP) ? rise[1] : rise[0];

    assign hit_lo  = (addr_i == A_LO);
    assign hit_hi  = (addr_i == A_HI);
    assign hit_msk = (addr_i == A_MSK);
    assign hit_flg = (addr_i == A_FLG);

    icu_cap_regs #(.CW(CW), .BW(BW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_i),
        .stb_i   (stb),
        .rd_lo_i (rd_en_i & hit_lo),
        .rd_hi_i (rd_en_i & hit_hi),
        .wr_lo_i (wr_en_i & hit_lo),
        .wr_hi_i (wr_en_i & hit_hi),
        .wdata_i (wdata_i),
        .rdata_o (cap_rd),
        .cap_o   (cap_val_o)
    );

    icu_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (stb),
        .wr_flg_i   (wr_en_i & hit_flg),
        .wr_msk_i   (wr_en_i & hit_msk),
        .wdata_i    (wdata_i),
        .gie_i      (global_ie_i),
        .cmpa_i     (cmpa_flag_i),
        .cmpb_i     (cmpb_flag_i),
        .ovf_i      (ovf_flag_i),
        .msk_o      (msk),
        .flg_o      (flg),
        .cap_flag_o (cap_flag_o),
        .irq_o      (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            if (hit_lo || hit_hi) rdata_o = cap_rd;
            else if (hit_msk)     rdata_o = msk;
            else if (hit_flg)     rdata_o = flg;
        end
    end

    p_irq_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !global_ie_i |-> irq_o == 4'b0000);
    p_irq_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[3] |-> cap_flag_o);
endmodule

// File: tb/icu_top_tb.sv
module icu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = '0;
    logic        cap_pin_i = 1'b0, cmp_out_i = 1'b0, src_sel_i = 1'b0;
    logic [7:0]  addr_i = '0, wdata_i = '0;
    logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [7:0]  rdata_o;
    logic        global_ie_i = 1'b0, cmpa_flag_i = 1'b0, cmpb_flag_i = 1'b0, ovf_flag_i = 1'b0;
    logic [15:0] cap_val_o;
    logic        cap_flag_o;
    logic [3:0]  irq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_LO = 8'h96, A_HI = 8'h97, A_MSK = 8'h6F, A_FLG = 8'h36;

    always #10 clk = ~clk;

    icu_top u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #5;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        addr_i = a; rd_en_i = 1'b1;
        #2 d = rdata_o;
        step();
        rd_en_i = 1'b0;
    endtask

    // raise a line, wait until the capture edge (k+2), drop it, settle
    task automatic pulse(input bit cmp, input logic [15:0] v);
        cnt_i = v;
        if (cmp) cmp_out_i = 1'b1; else cap_pin_i = 1'b1;
        step(); step(); step();
        cap_pin_i = 1'b0; cmp_out_i = 1'b0;
        step(); step(); step();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  d, lo, hi;
        logic [15:0] v, prev;
        #15; rst_n = 1'b1;
        step();

        // R10 reset state
        chk(cap_val_o == 16'h0, "R10 cap reset", cap_val_o, 16'h0);
        chk(cap_flag_o == 1'b0, "R10 flag reset", {15'b0, cap_flag_o}, 16'h0);
        bus_rd(A_MSK, d); chk(d == 8'h00, "R10 mask reset", {8'h0, d}, 16'h0);
        bus_rd(A_HI, d);  chk(d == 8'h00, "R10 temp reset", {8'h0, d}, 16'h0);
        bus_rd(8'h12, d); chk(d == 8'h00, "R10 unmapped read", {8'h0, d}, 16'h0);

        // R1 capture sweep via pin, bus readback R4
        src_sel_i = 1'b0;
        for (int i = 0; i < 24; i++) begin
            v = 16'(i * 16'h0B35 + 16'h1F07);
            pulse(1'b0, v);
            chk(cap_val_o == v, "R1 capture value", cap_val_o, v);
            bus_rd(A_LO, lo); bus_rd(A_HI, hi);
            chk({hi, lo} == v, "R4 byte readback", {hi, lo}, v);
        end
        chk(cap_flag_o == 1'b1, "R7 flag set by capture", {15'b0, cap_flag_o}, 16'h1);

        // R1 exact cycle: not yet at k+1, loaded at k+2
        cnt_i = 16'h4242; cap_pin_i = 1'b1;
        step(); step();
        chk(cap_val_o != 16'h4242, "R1 not before k+2", cap_val_o, 16'h0);
        step();
        chk(cap_val_o == 16'h4242, "R1 at k+2", cap_val_o, 16'h4242);
        // R3 held high: later counter values not captured
        bus_wr(A_FLG, 8'h20);
        chk(cap_flag_o == 1'b0, "R7 write one clears", {15'b0, cap_flag_o}, 16'h0);
        for (int i = 0; i < 8; i++) begin
            cnt_i = 16'(16'h9000 + i); step();
        end
        chk(cap_val_o == 16'h4242, "R3 held high no recapture", cap_val_o, 16'h4242);
        chk(cap_flag_o == 1'b0, "R3 held high no flag", {15'b0, cap_flag_o}, 16'h0);
        cap_pin_i = 1'b0; step(); step(); step();

        // R2 unselected comparator ignored
        pulse(1'b1, 16'h7777);
        chk(cap_val_o == 16'h4242, "R2 cmp ignored when pin selected", cap_val_o, 16'h4242);
        chk(cap_flag_o == 1'b0, "R2 cmp no flag", {15'b0, cap_flag_o}, 16'h0);
        src_sel_i = 1'b1; step();
        pulse(1'b1, 16'h7778);
        chk(cap_val_o == 16'h7778, "R2 cmp selected captures", cap_val_o, 16'h7778);
        bus_wr(A_FLG, 8'hFF);
        pulse(1'b0, 16'h1111);
        chk(cap_val_o == 16'h7778, "R2 pin ignored when cmp selected", cap_val_o, 16'h7778);
        chk(cap_flag_o == 1'b0, "R2 pin no flag", {15'b0, cap_flag_o}, 16'h0);
        src_sel_i = 1'b0; step();

        // R7 writing zero leaves flag
        pulse(1'b0, 16'h2222);
        bus_wr(A_FLG, 8'hDF);
        chk(cap_flag_o == 1'b1, "R7 write zero keeps flag", {15'b0, cap_flag_o}, 16'h1);
        bus_wr(A_FLG, 8'h20);
        // R7 set wins over simultaneous clear
        cnt_i = 16'h3333; cap_pin_i = 1'b1; step(); step();
        bus_wr(A_FLG, 8'h20);
        chk(cap_flag_o == 1'b1, "R7 set beats clear", {15'b0, cap_flag_o}, 16'h1);
        cap_pin_i = 1'b0; step(); step(); step();

        // R4 atomicity: capture between low and high read
        pulse(1'b0, 16'hA1B2);
        bus_rd(A_LO, lo);
        pulse(1'b0, 16'hC3D4);
        bus_rd(A_HI, hi);
        chk({hi, lo} == 16'hA1B2, "R4 temp holds high byte", {hi, lo}, 16'hA1B2);

        // R5 write path
        bus_wr(A_HI, 8'hAB);
        chk(cap_val_o == 16'hC3D4, "R5 high write no commit", cap_val_o, 16'hC3D4);
        bus_rd(A_HI, d);
        chk(d == 8'hAB, "R5 high write fills temp", {8'h0, d}, 16'h00AB);
        bus_wr(A_LO, 8'hCD);
        chk(cap_val_o == 16'hABCD, "R5 low write commits", cap_val_o, 16'hABCD);

        // R6 write beats capture in the same cycle
        bus_wr(A_HI, 8'h5A);
        cnt_i = 16'hEEEE; cap_pin_i = 1'b1; step(); step();
        bus_wr(A_LO, 8'h3C);
        chk(cap_val_o == 16'h5A3C, "R6 write beats capture", cap_val_o, 16'h5A3C);
        cap_pin_i = 1'b0; step(); step(); step();

        // R8 mask sweep
        for (int m = 0; m < 256; m++) begin
            bus_wr(A_MSK, 8'(m));
            bus_rd(A_MSK, d);
            chk(d == (8'(m) & 8'h27), "R8 mask readback", {8'h0, d}, {8'h0, 8'(m) & 8'h27});
        end

        // R7 flag register read of external flags
        cmpb_flag_i = 1'b1; cmpa_flag_i = 1'b0; ovf_flag_i = 1'b1;
        bus_wr(A_FLG, 8'h20);
        bus_rd(A_FLG, d);
        chk(d == 8'h05, "R7 flag reg layout", {8'h0, d}, 16'h0005);

        // R9 exhaustive gating sweep
        for (int cf = 0; cf < 2; cf++) begin
            if (cf == 1) pulse(1'b0, 16'h0F0F);
            else bus_wr(A_FLG, 8'h20);
            for (int m = 0; m < 16; m++) begin
                logic [3:0] mm;
                mm = 4'(m);
                bus_wr(A_MSK, {2'b00, mm[3], 2'b00, mm[2:0]});
                for (int e = 0; e < 16; e++) begin
                    logic [3:0] ee, exp;
                    ee = 4'(e);
                    cmpa_flag_i = ee[0]; cmpb_flag_i = ee[1]; ovf_flag_i = ee[2]; global_ie_i = ee[3];
                    exp = ee[3] ? {1'(cf) & mm[3], ee[1] & mm[2], ee[0] & mm[1], ee[2] & mm[0]} : 4'b0;
                    #1;
                    chk(irq_o == exp, "R9 irq gating", {12'h0, irq_o}, {12'h0, exp});
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule